// File: doc/BRIEF.md
# Multi-Mode Parallel Register Bus Port

This block gives a host processor byte-wide access to a peripheral's internal register file over one of three parallel bus styles, chosen by a two-bit mode input: split address and data buses addressed at the strobe, split buses with an address-latch pulse, or one shared byte bus that carries the address during the latch pulse and the data afterwards. The fourth mode code belongs to a serial link handled elsewhere, and it turns this port off.

The host's chip select, latch, write and read strobes are asynchronous to the system clock. They pass through two-flop synchronisers, and the edges seen in the clock domain start and end each access. Every access becomes a one-cycle request to the register file, which answers with an acknowledge a fixed number of cycles later. A ready output is enabled once the strobe is seen low. It is driven low until the acknowledge arrives, then high, and it is released when the strobe returns high. This lets the host stretch its bus cycle. The data bus is modelled as a value plus an output enable, and so is the ready pin.

Top module: `pbus_port`

## Requirements
- R1: With mode 00 (split buses, no latch), the access address is taken from the address bus at the synchronised falling edge of the write or read strobe.
- R2: With mode 01 (split buses with latch), the address bus is captured on every clock while the synchronised latch input is high and chip select is low. Later changes on the address bus do not affect the access.
- R3: With mode 10 (multiplexed), the address is captured from the shared bus while the latch is high. Write data is taken from the same bus during the write strobe.
- R4: With mode 11 (serial), the strobes start no access, the ready enable stays low and the data bus is never driven.
- R5: While chip select is high, the write, read and latch inputs are ignored: no register changes, the latched address is kept and ready stays undriven.
- R6: The data bus output enable is high exactly while chip select is low, the read strobe is low and the mode is not 11. Once ready is high, the bus carries the addressed register's contents.
- R7: The ready enable rises on the third clock after the strobe falls. Ready is driven low until the register file acknowledges, and driven high from the next clock.
- R8: The ready enable is released two clocks after the strobe is seen high. If the strobe rises before the acknowledge, ready still completes its low-then-high sequence before release.
- R9: Each access issues exactly one single-cycle request, and a write stores the captured data at the captured address.
- R10: With the default acknowledge latency of 3 clocks, ready goes high on the seventh clock after the strobe falls.
- R11: After reset, the ready enable is low and no access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Bus style: 00 split, 01 split with latch, 10 multiplexed, 11 serial (port off) |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr_in | input | AW (8) | Address bus for the split modes |
| ad_in | input | DW (8) | Data bus input, or the shared address/data bus in multiplexed mode |
| ad_out | output | DW (8) | Read data driven onto the data bus |
| ad_oe | output | 1 | Output enable for the data bus |
| rdy_out | output | 1 | Ready pin value: low while the access is pending, high when it is done |
| rdy_oe | output | 1 | Ready pin output enable (released means high impedance) |

## Verification
On every clock, the assertions check that a request lasts one cycle and never overlaps a pending one. They also check that ready rises only after an acknowledge, that the ready enable is released only after ready went high, and that no access starts with chip select high or in serial mode. The bench's scenarios are needed to show which address each bus style actually captures and that a latch pulse with chip select high leaves the latched address alone. They also show the exact clock counts from strobe to ready, and that a strobe pulse shorter than the acknowledge latency still completes the write.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT       = 2'b00,
    MODE_SPLIT_LATCH = 2'b01,
    MODE_MUXED       = 2'b10,
    MODE_SERIAL      = 2'b11
  } bus_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } acc_state_e;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int         W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= din[i];
        sync_q <= meta_q;
      end
    end
    assign dout[i] = sync_q;
  end
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int ACK_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic          ack,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(ACK_LAT + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] pend_q;

  always_comb begin
    cnt_d = cnt_q;
    if (req)                 cnt_d = CW'(ACK_LAT);
    else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (req) pend_q <= addr;
    end
  end

  always_ff @(posedge clk) begin
    if (req && we) mem[addr] <= wdata;
  end

  assign ack   = (cnt_q == CW'(1));
  assign rdata = mem[pend_q];

  // R9: a new request never lands on one still pending
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (cnt_q == '0));
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_mode_e     mode,
  input  logic          s_cs_n,
  input  logic          s_ale,
  input  logic          s_wr_n,
  input  logic          s_rd_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] ad_in,
  input  logic          ack,
  input  logic [DW-1:0] rdata,
  output logic          req,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic          req_we,
  output logic [DW-1:0] rd_hold,
  output logic          rdy_out,
  output logic          rdy_oe
);
  acc_state_e    state_q, state_d;
  logic          wr_q, rd_q;
  logic [AW-1:0] lat_addr_q;
  logic [AW-1:0] acc_addr_q;
  logic [DW-1:0] acc_wdata_q;
  logic          acc_we_q;

  logic          wr_fall, rd_fall, port_on, start, lat_en, cap_rd, strobe_up;
  logic [AW-1:0] lat_d, acc_addr_d;

  assign wr_fall    = wr_q & ~s_wr_n;
  assign rd_fall    = rd_q & ~s_rd_n;
  assign port_on    = (mode != MODE_SERIAL) & ~s_cs_n;
  assign start      = (state_q == ST_IDLE) & port_on & (wr_fall | rd_fall);
  assign lat_en     = ((mode == MODE_SPLIT_LATCH) | (mode == MODE_MUXED)) & ~s_cs_n & s_ale;
  assign lat_d      = (mode == MODE_MUXED) ? ad_in[AW-1:0] : addr_in;
  assign acc_addr_d = (mode == MODE_SPLIT) ? addr_in : lat_addr_q;
  assign cap_rd     = (state_q == ST_WAIT) & ack;
  assign strobe_up  = acc_we_q ? s_wr_n : s_rd_n;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)     state_d = ST_ISSUE;
      ST_ISSUE:                state_d = ST_WAIT;
      ST_WAIT:  if (ack)       state_d = ST_HOLD;
      ST_HOLD:  if (strobe_up) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wr_q        <= 1'b1;
      rd_q        <= 1'b1;
      lat_addr_q  <= '0;
      acc_addr_q  <= '0;
      acc_wdata_q <= '0;
      acc_we_q    <= 1'b0;
      rd_hold     <= '0;
    end else begin
      state_q <= state_d;
      wr_q    <= s_wr_n;
      rd_q    <= s_rd_n;
      if (lat_en) lat_addr_q <= lat_d;
      if (start) begin
        acc_addr_q  <= acc_addr_d;
        acc_wdata_q <= ad_in;
        acc_we_q    <= wr_fall;
      end
      if (cap_rd) rd_hold <= rdata;
    end
  end

  assign req       = (state_q == ST_ISSUE);
  assign req_addr  = acc_addr_q;
  assign req_wdata = acc_wdata_q;
  assign req_we    = acc_we_q;
  assign rdy_oe    = (state_q != ST_IDLE);
  assign rdy_out   = (state_q == ST_HOLD);

  // R9: request is a one-cycle pulse
  a_r9_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R7: ready goes high only after the register file answered
  a_r7_rdy_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_out) |-> $past(ack));
  // R8: the ready pin is released only after it showed completion
  a_r8_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_oe) |-> $past(rdy_out));
  // R5: no access begins while chip select is high
  a_r5_cs_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && s_cs_n) |=> (state_q != ST_ISSUE));
  // R4: serial mode keeps the parallel port idle
  a_r4_serial_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && mode == MODE_SERIAL) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pbus_port.sv
module pbus_port
  import pbus_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int ACK_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          cs_n,
  input  logic          ale,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          rdy_out,
  output logic          rdy_oe
);
  localparam int          NSYNC    = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1011;  // cs_n, ale, wr_n, rd_n

  logic       rst_m_q, rst_s_q;
  logic [NSYNC-1:0] raw_pins, s_pins;
  bus_mode_e  mode_e;

  logic          req, req_we, ack;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  assign mode_e   = bus_mode_e'(mode);
  assign raw_pins = {cs_n, ale, wr_n, rd_n};

  pbus_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_s_q),
    .din  (raw_pins),
    .dout (s_pins)
  );

  pbus_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .mode     (mode_e),
    .s_cs_n   (s_pins[3]),
    .s_ale    (s_pins[2]),
    .s_wr_n   (s_pins[1]),
    .s_rd_n   (s_pins[0]),
    .addr_in  (addr_in),
    .ad_in    (ad_in),
    .ack      (ack),
    .rdata    (rdata),
    .req      (req),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_we   (req_we),
    .rd_hold  (ad_out),
    .rdy_out  (rdy_out),
    .rdy_oe   (rdy_oe)
  );

  pbus_regfile #(.AW(AW), .DW(DW), .ACK_LAT(ACK_LAT)) u_regs (
    .clk  (clk),
    .rst_n(rst_s_q),
    .req  (req),
    .addr (req_addr),
    .wdata(req_wdata),
    .we   (req_we),
    .ack  (ack),
    .rdata(rdata)
  );

  assign ad_oe = ~cs_n & ~rd_n & (mode_e != MODE_SERIAL);
endmodule

// File: tb/pbus_port_test.sv
module pbus_port_test;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       cs_n, ale, wr_n, rd_n;
  logic [7:0] addr_in, ad_in;
  logic [7:0] ad_out;
  logic       ad_oe, rdy_out, rdy_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pbus_port #(.AW(8), .DW(8), .ACK_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .ale(ale),
    .wr_n(wr_n), .rd_n(rd_n), .addr_in(addr_in), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .rdy_out(rdy_out), .rdy_oe(rdy_oe)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [3:0] p1, p2, p3;   // pin samples {cs_n, ale, wr_n, rd_n}, 1..3 edges back
  int   mst, mcnt, maddr, mlat;
  bit   mwe;
  int   mmem [int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = 4'b1011; p2 = 4'b1011; p3 = 4'b1011;
      mst = 0; mcnt = 0; mwe = 1'b0; maddr = 0; mlat = 0;
    end else begin
      case (mst)
        0: begin
          bit wf, rf;
          wf = p3[1] && !p2[1];
          rf = p3[0] && !p2[0];
          if (!p2[3] && mode != 2'b11 && (wf || rf)) begin
            mwe   = wf;
            maddr = (mode == 2'b00) ? int'(addr_in) : mlat;
            if (mwe) mmem[maddr] = int'(ad_in);
            mst = 1;
          end
        end
        1: begin mcnt = LAT; mst = 2; end
        2: begin mcnt--; if (mcnt == 0) mst = 3; end
        default: if (mwe ? p2[1] : p2[0]) mst = 0;
      endcase
      if (p2[2] && !p2[3] && (mode == 2'b01 || mode == 2'b10))
        mlat = (mode == 2'b10) ? int'(ad_in) : int'(addr_in);
      p3 = p2; p2 = p1; p1 = {cs_n, ale, wr_n, rd_n};
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check_eq("R7/R8/R11 rdy_oe", int'(rdy_oe), int'(mst != 0));
      check_eq("R7 rdy_out", int'(rdy_out), int'(mst == 3));
      check_eq("R6 ad_oe", int'(ad_oe), int'(!cs_n && !rd_n && mode != 2'b11));
      if (mst == 3 && !mwe && ad_oe && mmem.exists(maddr))
        check_eq("R6 ad_out", int'(ad_out), mmem[maddr]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle_pins();
    cs_n = 1'b1; ale = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
  endtask

  // waits after a strobe fall; returns negedge counts to rdy_oe and rdy_out
  task automatic wait_ready(output int n_oe, output int n_rdy, output logic [7:0] dat);
    n_oe = 0; n_rdy = 0; dat = '0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (rdy_oe && n_oe == 0) n_oe = i;
      if (rdy_out) begin n_rdy = i; dat = ad_out; break; end
    end
    #1;
  endtask

  task automatic wait_release();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!rdy_oe) break;
    end
    #1;
  endtask

  task automatic access(input int md, input bit we, input logic [7:0] a,
                        input logic [7:0] d, output logic [7:0] rd,
                        output int n_oe, output int n_rdy);
    mode = md[1:0];
    cs_n = 1'b0;
    if (md == 1) begin
      addr_in = a; ale = 1'b1; step(3); ale = 1'b0; step(3);
      addr_in = ~a;                      // latched address must win
    end else if (md == 2) begin
      ad_in = a; ale = 1'b1; step(3); ale = 1'b0; step(3);
    end else begin
      addr_in = a; step(1);
    end
    if (we) begin ad_in = d; wr_n = 1'b0; end
    else    begin ad_in = 8'h00; rd_n = 1'b0; end
    wait_ready(n_oe, n_rdy, rd);
    wr_n = 1'b1; rd_n = 1'b1;
    wait_release();
    idle_pins();
    step(2);
  endtask

  initial begin
    #200_000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    int noe, nrdy;
    rst_n = 1'b0; mode = 2'b00; addr_in = '0; ad_in = '0;
    idle_pins();
    step(4);
    check_eq("R11 reset rdy_oe", int'(rdy_oe), 0);
    rst_n = 1'b1;
    step(5);
    check_eq("R11 idle rdy_oe", int'(rdy_oe), 0);

    // R1 split buses, R10/R7 timing on a write
    access(0, 1'b1, 8'h12, 8'hA5, rv, noe, nrdy);
    check_eq("R7 oe delay", noe, 3);
    check_eq("R10 ready delay", nrdy, LAT + 4);
    access(0, 1'b1, 8'h34, 8'h5A, rv, noe, nrdy);
    access(0, 1'b0, 8'h12, 8'h00, rv, noe, nrdy);
    check_eq("R1 read 12", int'(rv), 'hA5);
    check_eq("R10 read ready delay", nrdy, LAT + 4);

    // R2 latched split buses
    access(1, 1'b1, 8'h40, 8'h3C, rv, noe, nrdy);
    access(1, 1'b0, 8'h40, 8'h00, rv, noe, nrdy);
    check_eq("R2 latched read", int'(rv), 'h3C);
    access(0, 1'b0, 8'hBF, 8'h00, rv, noe, nrdy);   // ~8'h40 untouched
    check_eq("R2 alt addr untouched", int'(rv) == 'h3C ? 1 : 0, 0);

    // R3 multiplexed bus
    access(2, 1'b1, 8'h77, 8'hC3, rv, noe, nrdy);
    access(2, 1'b0, 8'h34, 8'h00, rv, noe, nrdy);
    check_eq("R3 mux read 34", int'(rv), 'h5A);
    access(0, 1'b0, 8'h77, 8'h00, rv, noe, nrdy);
    check_eq("R3 mux write 77", int'(rv), 'hC3);

    // R4 serial mode: strobes do nothing
    mode = 2'b11; cs_n = 1'b0; addr_in = 8'h12; ad_in = 8'hEE; wr_n = 1'b0;
    step(10);
    check_eq("R4 serial rdy_oe", int'(rdy_oe), 0);
    wr_n = 1'b1; rd_n = 1'b0; step(2);
    check_eq("R4 serial ad_oe", int'(ad_oe), 0);
    idle_pins(); step(3);
    access(0, 1'b0, 8'h12, 8'h00, rv, noe, nrdy);
    check_eq("R4 memory kept", int'(rv), 'hA5);

    // R5 chip select high: write and latch ignored
    mode = 2'b00; cs_n = 1'b1; addr_in = 8'h34; ad_in = 8'h99; wr_n = 1'b0;
    step(10);
    check_eq("R5 cs high rdy_oe", int'(rdy_oe), 0);
    wr_n = 1'b1; rd_n = 1'b0; step(2);
    check_eq("R5 cs high ad_oe", int'(ad_oe), 0);
    idle_pins(); step(3);
    access(1, 1'b1, 8'h50, 8'h11, rv, noe, nrdy);   // latch holds 50
    mode = 2'b01; cs_n = 1'b1; addr_in = 8'h51; ale = 1'b1; step(4);
    ale = 1'b0; step(3);
    cs_n = 1'b0; step(3);
    ad_in = 8'h22; wr_n = 1'b0;
    wait_ready(noe, nrdy, rv);
    wr_n = 1'b1; wait_release(); idle_pins(); step(2);
    access(0, 1'b0, 8'h50, 8'h00, rv, noe, nrdy);
    check_eq("R5 latch kept under cs high", int'(rv), 'h22);
    access(0, 1'b0, 8'h34, 8'h00, rv, noe, nrdy);
    check_eq("R5 ignored write", int'(rv), 'h5A);

    // R8/R9 short strobe ends before acknowledge
    mode = 2'b00; cs_n = 1'b0; addr_in = 8'h60; ad_in = 8'h6D; step(1);
    wr_n = 1'b0; step(1); wr_n = 1'b1;
    wait_ready(noe, nrdy, rv);
    check_eq("R8 short strobe still completes", int'(nrdy != 0), 1);
    wait_release();
    check_eq("R8 released", int'(rdy_oe), 0);
    idle_pins(); step(2);
    access(0, 1'b0, 8'h60, 8'h00, rv, noe, nrdy);
    check_eq("R9 short write stored", int'(rv), 'h6D);

    step(5);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule